// File: doc/BRIEF.md
# Double-Buffered Configuration Bank with Deferred Update

This block holds a pattern generator's configuration in two copies. Every register write from the host lands in a shadow copy. A separate active copy is the only one the generator sees. The two copies stay apart until software asks for an update. The block then copies the shadow set into the active set, but only once the generator reports that it is not running.

Software requests the update by writing a 1 to the arm bit of a dedicated control address. From then on the request is pending, and the status output stays high until the copy has been made. All registers are copied on one clock edge, so the generator never sees a half-updated set. Writes to addresses outside the register range and apart from the control address have no effect. These addresses include the waveform-memory space, which is not double-buffered. They change neither copy.

Top module: `cfg_dbuf_ctrl`

## Requirements
- R1: After reset, every active register, every shadow register and the pending status read 0.
- R2: A write with `wr_addr_i` below `NUM_REGS` stores `wr_data_i` into shadow register `wr_addr_i` on that clock edge. It leaves every active register unchanged.
- R3: A write to `CTRL_ADDR` with bit 0 of `wr_data_i` set raises `pending_o` on that edge. A write to `CTRL_ADDR` with bit 0 clear leaves `pending_o` as it was.
- R4: While `gen_run_i` is 1, the active registers do not change and a pending update stays pending.
- R5: On an edge where `pending_o` is 1 and `gen_run_i` is 0, all active registers take their shadow values together and `pending_o` falls.
- R6: If the generator is already idle when the arm write is made, the active set is updated on the edge after the one that stored the arm write.
- R7: A shadow write made in the same cycle as a transfer does not reach the active set in that transfer. It stays in the shadow copy and is moved by the next update.
- R8: An arm write made in the same cycle as a transfer leaves `pending_o` at 1, so a second transfer follows.
- R9: Writes to any address that is neither below `NUM_REGS` nor equal to `CTRL_ADDR` change no shadow register, no active register and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| gen_run_i | input | 1 | Pattern generator running flag |
| act_o | output | NUM_REGS*DATA_W | Active registers, register i at bits [i*DATA_W +: DATA_W] |
| pending_o | output | 1 | Update armed and not yet applied |

## Verification
The bench builds the block with four 12-bit registers, an 8-bit address and the control address at 0x40. With only four registers, every register of the active set can be compared after each transfer. The 8-bit address space also leaves room for several ignored addresses, both just above the register range and just above the control address. The directed scenarios also drive the cases where two events land on the transfer edge: a shadow write in that cycle, and a re-arm in that cycle.

// File: rtl/cfg_dbuf_pkg.sv
`timescale 1ns/1ps
package cfg_dbuf_pkg;
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_REG   = 2'd1,
        WR_ARM   = 2'd2,
        WR_OTHER = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/cfg_wr_decode.sv
`timescale 1ns/1ps
module cfg_wr_decode
    import cfg_dbuf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_REGS  = 4,
    parameter int CTRL_ADDR = 64,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              arm_bit_i,
    output wr_kind_e          kind_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        kind_o = WR_NONE;
        idx_o  = wr_addr_i[IDX_W-1:0];
        if (wr_en_i) begin
            if (wr_addr_i < ADDR_W'(NUM_REGS))
                kind_o = WR_REG;
            else if (wr_addr_i == ADDR_W'(CTRL_ADDR))
                kind_o = arm_bit_i ? WR_ARM : WR_OTHER;
            else
                kind_o = WR_OTHER;
        end
    end
endmodule

// File: rtl/cfg_shadow_bank.sv
`timescale 1ns/1ps
module cfg_shadow_bank #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [DATA_W-1:0]                data_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  shadow_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (we_i)
            sh_d.regs[idx_i] = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign shadow_o = sh_q.regs;

    AST_SHADOW_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> sh_q.regs[$past(idx_i)] == $past(data_i)); // R2
    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(sh_q)); // R9
endmodule

// File: rtl/cfg_update_seq.sv
`timescale 1ns/1ps
module cfg_update_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic gen_run_i,
    output logic xfer_o,
    output logic pending_o
);
    typedef struct packed {
        logic pending;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        xfer_o = seq_q.pending && !gen_run_i;
        if (xfer_o) seq_d.pending = 1'b0;
        if (arm_i)  seq_d.pending = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pending_o = seq_q.pending;

    AST_ARM_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> seq_q.pending); // R3
    AST_NO_SELF_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.pending && !arm_i |=> !seq_q.pending); // R3
    AST_BUSY_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.pending && gen_run_i |=> seq_q.pending); // R4
    AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.pending && !gen_run_i && !arm_i |=> !seq_q.pending); // R5
    AST_REARM_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o && arm_i |=> seq_q.pending); // R8
endmodule

// File: rtl/cfg_active_bank.sv
`timescale 1ns/1ps
module cfg_active_bank #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             xfer_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  shadow_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  active_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } act_state_t;

    act_state_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (xfer_i)
            act_d.regs = shadow_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign active_o = act_q.regs;

    AST_WHOLE_SET_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> act_q.regs == $past(shadow_i)); // R5
    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> $stable(act_q)); // R2
endmodule

// File: rtl/cfg_dbuf_ctrl.sv
`timescale 1ns/1ps
module cfg_dbuf_ctrl
    import cfg_dbuf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 4,
    parameter int CTRL_ADDR = 64,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic                         gen_run_i,
    output logic [NUM_REGS*DATA_W-1:0]   act_o,
    output logic                         pending_o
);
    wr_kind_e                         kind;
    logic [IDX_W-1:0]                 idx;
    logic                             xfer;
    logic [NUM_REGS-1:0][DATA_W-1:0]  shadow;
    logic [NUM_REGS-1:0][DATA_W-1:0]  active;

    cfg_wr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .arm_bit_i(wr_data_i[0]),
        .kind_o(kind), .idx_o(idx)
    );

    cfg_shadow_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_shadow (
        .clk(clk), .rst_n(rst_n), .we_i(kind == WR_REG), .idx_i(idx),
        .data_i(wr_data_i), .shadow_o(shadow)
    );

    cfg_update_seq u_seq (
        .clk(clk), .rst_n(rst_n), .arm_i(kind == WR_ARM),
        .gen_run_i(gen_run_i), .xfer_o(xfer), .pending_o(pending_o)
    );

    cfg_active_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_active (
        .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .shadow_i(shadow),
        .active_o(active)
    );

    assign act_o = active;

    AST_RUN_FREEZES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        gen_run_i |=> $stable(act_o)); // R4
    AST_IDLE_NO_PENDING_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |=> $stable(act_o)); // R2
endmodule

// File: tb/tb_cfg_dbuf_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_dbuf_ctrl;
    localparam int AW = 8;
    localparam int DW = 12;
    localparam int NR = 4;
    localparam int CA = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic gen_run = 1'b0;
    logic [NR*DW-1:0] act;
    logic pending;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_sh  [NR];
    logic [DW-1:0] exp_act [NR];

    always #2.5 clk = ~clk;

    cfg_dbuf_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR), .CTRL_ADDR(CA)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .gen_run_i(gen_run), .act_o(act), .pending_o(pending)
    );

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_act(string tag);
        for (int i = 0; i < NR; i++)
            chk(tag, act[i*DW +: DW], exp_act[i]);
    endtask

    task automatic chk_pend(string tag, logic exp);
        chk(tag, {{(DW-1){1'b0}}, pending}, {{(DW-1){1'b0}}, exp});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one write, starting and ending at a falling edge
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < AW'(NR)) exp_sh[a[1:0]] = d;
    endtask

    task automatic apply_model();
        for (int i = 0; i < NR; i++) exp_act[i] = exp_sh[i];
    endtask

    task automatic t_reset();
        rst_n = 1'b0; gen_run = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        for (int i = 0; i < NR; i++) begin exp_sh[i] = '0; exp_act[i] = '0; end
        chk_act("R1 active after reset");
        chk_pend("R1 pending after reset", 1'b0);
        wr(AW'(CA), 12'h001);
        step();
        chk_act("R1 shadow reset value moved");
        chk_pend("R1 pending cleared", 1'b0);
    endtask

    task automatic t_busy_then_idle();
        gen_run = 1'b1;
        for (int i = 0; i < NR; i++) wr(AW'(i), 12'hA10 + 12'(i));
        chk_act("R2 shadow writes leave active");
        wr(AW'(CA), 12'h001);
        chk_pend("R3 arm raises pending", 1'b1);
        repeat (3) step();
        chk_pend("R4 pending held while running", 1'b1);
        chk_act("R4 active frozen while running");
        gen_run = 1'b0;
        step();
        apply_model();
        chk_act("R5 whole set copied");
        chk_pend("R5 pending falls", 1'b0);
    endtask

    task automatic t_immediate();
        gen_run = 1'b0;
        wr(AW'(1), 12'h5C3);
        wr(AW'(CA), 12'h801);
        chk_pend("R6 pending after arm", 1'b1);
        chk_act("R6 not yet copied");
        step();
        apply_model();
        chk_act("R6 copied next cycle");
        chk_pend("R6 pending cleared", 1'b0);
    endtask

    task automatic t_arm_zero();
        wr(AW'(2), 12'h3E7);
        wr(AW'(CA), 12'hFFE);
        chk_pend("R3 bit0 clear does not arm", 1'b0);
        step();
        chk_act("R3 no transfer without arm");
    endtask

    task automatic t_ignored();
        wr(AW'(NR), 12'hBAD);
        wr(AW'(CA + 1), 12'hFFF);
        wr(AW'(8'hFF), 12'hFFF);
        wr(AW'(8'h60), 12'h001);
        chk_pend("R9 ignored writes do not arm", 1'b0);
        chk_act("R9 active untouched");
        wr(AW'(CA), 12'h001);
        step();
        apply_model();
        chk_act("R9 shadow untouched by ignored writes");
    endtask

    task automatic t_overlap();
        logic [DW-1:0] first_v;
        gen_run = 1'b1;
        wr(AW'(0), 12'h111);
        first_v = exp_sh[0];
        wr(AW'(CA), 12'h001);
        gen_run = 1'b0;
        wr(AW'(0), 12'h222);
        chk(" R7 transfer takes old shadow", act[0 +: DW], first_v);
        chk_pend("R7 pending cleared", 1'b0);
        wr(AW'(CA), 12'h001);
        step();
        apply_model();
        chk(" R7 held write moved later", act[0 +: DW], 12'h222);
    endtask

    task automatic t_rearm();
        gen_run = 1'b1;
        wr(AW'(3), 12'h4F4);
        wr(AW'(CA), 12'h001);
        gen_run = 1'b0;
        wr(AW'(CA), 12'h001);
        apply_model();
        chk_pend("R8 re-arm keeps pending", 1'b1);
        chk_act("R8 first transfer done");
        step();
        chk_pend("R8 second transfer clears", 1'b0);
        chk_act("R8 active after second transfer");
    endtask

    initial begin
        t_reset();
        t_busy_then_idle();
        t_immediate();
        t_arm_zero();
        t_ignored();
        t_overlap();
        t_rearm();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule